// File: doc/BRIEF.md
# Cyclic-Memory Contribution Event Scheduler

This block serves many sparse arithmetic progressions whose step is large compared with the number of sieve lanes. Each pending hit is kept as an event (step, target index, weight) in a small cyclic event memory. The memory is split into buckets, and each bucket stands for one group of `LANES` consecutive indices. A read head walks the memory one slot per cycle. After all slots of a bucket have been visited, the current group advances by one.

When the head finds an event whose index lies in the current group (or in an earlier group), the block emits a contribution toward the sieve pipeline. The contribution carries the lane (`index mod LANES`), the stored 8-bit weight and the index itself. The event is then moved forward by its step and written into the bucket that will be read when the new index comes up. This sits ahead of the head, so storage freed behind the head is reused as it circles round.

Each bucket holds only a few slots. When the target bucket is full, the event goes into the following bucket, where it is emitted one group late, and a collision counter is bumped. Events are loaded while the scheduler is paused. Correct operation assumes that every step lies between `2*LANES` and `(NBUCK-2)*LANES-(LANES-1)`, and that no event is loaded more than one lap ahead. `LANES`, `NBUCK` and `SLOTS` must be powers of two, and `SLOTS` must be at least 2.

Top module: `evsched_top`

## Requirements
- R1: After reset `out_valid` is 0, `coll_cnt` is 0 and every slot is empty, so running without loads emits nothing.
- R2: With `run` low, a cycle with `ld_en` high stores the event in bucket `(ld_a >> log2(LANES)) mod NBUCK`. With `run` high, `ld_en` is ignored and the event never appears at the output.
- R3: While `run` is low the head and the group hold still, and `out_valid` is 0 in the cycle after each non-running cycle.
- R4: Each running cycle reads one slot, in order slot 0 to `SLOTS-1` of bucket `group mod NBUCK`; the group increments after the last slot. A contribution for the read made at a clock edge is visible right after that same edge.
- R5: An event is emitted only when its group (`index >> log2(LANES)`) is not later than the current group. An event one lap or more ahead stays in place untouched.
- R6: An emitted contribution carries `out_lane = index mod LANES`, the event's stored weight on `out_w`, and its index on `out_idx`.
- R7: After emission, the event is rescheduled with index + step and the same step and weight, so each progression emits the indices a, a+p, a+2p, ... in order and none is skipped.
- R8: An event is written into the lowest free slot of its target bucket. If that bucket is full, it goes to the next bucket, `coll_cnt` increments by one, and the event is emitted one group late.
- R9: An empty slot under the head produces no contribution and no write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| run | input | 1 | Advance the head and process one slot this cycle |
| ld_en | input | 1 | Load an event (only while run is low) |
| ld_p | input | P_W | Step of the loaded progression |
| ld_a | input | IDX_W | First target index of the loaded progression |
| ld_w | input | 8 | Weight of the loaded progression |
| out_valid | output | 1 | Contribution present |
| out_lane | output | log2(LANES) | Pipeline lane of the contribution |
| out_w | output | 8 | Weight to add on that lane |
| out_idx | output | IDX_W | Index the contribution belongs to |
| coll_cnt | output | COLL_W | Number of full-bucket spills |

## Verification
The main stimulus is a set of random progressions with random steps and phases. The bench follows each progression through its exact index sequence and the group in which each index appears, which separates a wrong reschedule from a wrong bucket choice. Directed patterns add a single event, whose first read slot pins down the head order. They also add an event one lap ahead, which shows that future events are held rather than emitted early, and three events sharing one group, which forces a spill and a one-group-late emission. Pause windows and a load attempted while running show that nothing moves or appears outside a running cycle.

// File: rtl/evsched_pkg.sv
// Shared types for the event scheduler.
package evsched_pkg;
    localparam int WEIGHT_W = 8;
    typedef logic [WEIGHT_W-1:0] weight_t;
endpackage

// File: rtl/evsched_freepick.sv
// Finds the lowest free slot among the busy flags of one bucket.
// Assumes: SLOTS >= 2.
module evsched_freepick #(
    parameter int SLOTS = 2,
    localparam int SL_W = $clog2(SLOTS)
) (
    input  logic [SLOTS-1:0] busy,
    output logic             found,
    output logic [SL_W-1:0]  slot
);
    // Priority scan: lowest free index wins
    always_comb begin
        found = 1'b0;
        slot  = '0;
        for (int i = SLOTS - 1; i >= 0; i--) begin
            if (!busy[i]) begin
                found = 1'b1;
                slot  = SL_W'(i);
            end
        end
    end
endmodule

// File: rtl/evsched_head.sv
// Read head: slot pointer within the current bucket plus the group counter.
// Assumes: SLOTS and NBUCK are powers of two; the bucket is group mod NBUCK.
module evsched_head #(
    parameter int NBUCK = 8,
    parameter int SLOTS = 2,
    parameter int GRP_W = 14,
    localparam int BK_W = $clog2(NBUCK),
    localparam int SL_W = $clog2(SLOTS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv,
    output logic [SL_W-1:0]  hd_slot,
    output logic [GRP_W-1:0] hd_grp,
    output logic [BK_W-1:0]  hd_bucket
);
    // Step the slot each running cycle; wrap into the next group
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hd_slot <= '0;
            hd_grp  <= '0;
        end else if (adv) begin
            if (hd_slot == SL_W'(SLOTS - 1)) begin
                hd_slot <= '0;
                hd_grp  <= hd_grp + 1'b1;
            end else begin
                hd_slot <= hd_slot + 1'b1;
            end
        end
    end

    assign hd_bucket = hd_grp[BK_W-1:0];

    // R3
    head_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !adv |=> ($stable(hd_grp) && $stable(hd_slot)));

    // R4
    grp_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (hd_grp == $past(hd_grp) || hd_grp == $past(hd_grp) + 1'b1));
endmodule

// File: rtl/evsched_place.sv
// Chooses where an incoming event is stored: lowest free slot of the target
// bucket, else lowest free slot of the following bucket (a collision).
// If both are full the event is not written.
module evsched_place #(
    parameter int NBUCK = 8,
    parameter int SLOTS = 2,
    localparam int BK_W = $clog2(NBUCK),
    localparam int SL_W = $clog2(SLOTS)
) (
    input  logic             src_v,
    input  logic [BK_W-1:0]  tgt_bk,
    input  logic [SLOTS-1:0] busy_tgt,
    input  logic [SLOTS-1:0] busy_nxt,
    output logic             wr_en,
    output logic [BK_W-1:0]  wr_bk,
    output logic [SL_W-1:0]  wr_sl,
    output logic             coll
);
    logic            f_t, f_n;
    logic [SL_W-1:0] s_t, s_n;

    evsched_freepick #(.SLOTS(SLOTS)) u_pick_t (.busy(busy_tgt), .found(f_t), .slot(s_t));
    evsched_freepick #(.SLOTS(SLOTS)) u_pick_n (.busy(busy_nxt), .found(f_n), .slot(s_n));

    // Select target or spill bucket and flag the spill
    always_comb begin
        wr_en = 1'b0;
        wr_bk = tgt_bk;
        wr_sl = s_t;
        coll  = 1'b0;
        if (src_v) begin
            if (f_t) begin
                wr_en = 1'b1;
            end else begin
                coll  = 1'b1;
                wr_bk = tgt_bk + 1'b1;
                wr_sl = s_n;
                wr_en = f_n;
            end
        end
    end
endmodule

// File: rtl/evsched_top.sv
// Cyclic event scheduler. One slot is read per running cycle; a due event
// emits (lane, weight, index) one register later and is rescheduled by its
// step into the bucket of its new group. Loads are accepted only while paused.
// Assumes: 2*LANES <= step and the new group is at most NBUCK-2 groups ahead.
module evsched_top #(
    parameter int LANES  = 4,
    parameter int NBUCK  = 8,
    parameter int SLOTS  = 2,
    parameter int IDX_W  = 16,
    parameter int P_W    = 8,
    parameter int COLL_W = 16,
    localparam int LS    = $clog2(LANES),
    localparam int BK_W  = $clog2(NBUCK),
    localparam int SL_W  = $clog2(SLOTS),
    localparam int AD_W  = BK_W + SL_W,
    localparam int NENT  = NBUCK * SLOTS,
    localparam int GRP_W = IDX_W - LS
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     run,
    input  logic                     ld_en,
    input  logic [P_W-1:0]           ld_p,
    input  logic [IDX_W-1:0]         ld_a,
    input  evsched_pkg::weight_t     ld_w,
    output logic                     out_valid,
    output logic [LS-1:0]            out_lane,
    output evsched_pkg::weight_t     out_w,
    output logic [IDX_W-1:0]         out_idx,
    output logic [COLL_W-1:0]        coll_cnt
);
    import evsched_pkg::*;

    // Event storage
    logic [NENT-1:0]  mem_v;
    logic [P_W-1:0]   mem_p [NENT];
    logic [IDX_W-1:0] mem_a [NENT];
    weight_t          mem_w [NENT];

    logic [SL_W-1:0]  hd_slot;
    logic [GRP_W-1:0] hd_grp;
    logic [BK_W-1:0]  hd_bucket;

    evsched_head #(.NBUCK(NBUCK), .SLOTS(SLOTS), .GRP_W(GRP_W)) u_head (
        .clk(clk), .rst_n(rst_n), .adv(run),
        .hd_slot(hd_slot), .hd_grp(hd_grp), .hd_bucket(hd_bucket)
    );

    // Read side
    logic [AD_W-1:0]  rd_addr;
    logic             rd_v, due, emit;
    logic [IDX_W-1:0] rd_a, nxt_a;
    assign rd_addr = {hd_bucket, hd_slot};
    assign rd_v    = mem_v[rd_addr];
    assign rd_a    = mem_a[rd_addr];
    assign due     = rd_v && (rd_a[IDX_W-1:LS] <= hd_grp);
    assign emit    = run && due;
    assign nxt_a   = rd_a + IDX_W'(mem_p[rd_addr]);

    // Source of the write: rescheduled event while running, load while paused
    logic             src_v;
    logic [IDX_W-1:0] src_a;
    logic [P_W-1:0]   src_p;
    weight_t          src_w;
    always_comb begin
        if (run) begin
            src_v = emit;
            src_a = nxt_a;
            src_p = mem_p[rd_addr];
            src_w = mem_w[rd_addr];
        end else begin
            src_v = ld_en;
            src_a = ld_a;
            src_p = ld_p;
            src_w = ld_w;
        end
    end

    // Per-bucket busy flags
    logic [SLOTS-1:0] bk_busy [NBUCK];
    for (genvar b = 0; b < NBUCK; b++) begin : g_busy
        assign bk_busy[b] = mem_v[b*SLOTS +: SLOTS];
    end

    logic [BK_W-1:0] tgt_bk, nxt_bk, wr_bk;
    logic [SL_W-1:0] wr_sl;
    logic            wr_en, coll;
    logic [AD_W-1:0] wr_addr;
    assign tgt_bk  = src_a[LS +: BK_W];
    assign nxt_bk  = tgt_bk + 1'b1;
    assign wr_addr = {wr_bk, wr_sl};

    evsched_place #(.NBUCK(NBUCK), .SLOTS(SLOTS)) u_place (
        .src_v(src_v), .tgt_bk(tgt_bk),
        .busy_tgt(bk_busy[tgt_bk]), .busy_nxt(bk_busy[nxt_bk]),
        .wr_en(wr_en), .wr_bk(wr_bk), .wr_sl(wr_sl), .coll(coll)
    );

    // Valid flags: free the consumed slot, then claim the written one
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_v <= '0;
        end else begin
            if (emit)  mem_v[rd_addr] <= 1'b0;
            if (wr_en) mem_v[wr_addr] <= 1'b1;
        end
    end

    // Event payload write
    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem_p[wr_addr] <= src_p;
            mem_a[wr_addr] <= src_a;
            mem_w[wr_addr] <= src_w;
        end
    end

    // Contribution register toward the pipeline
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_lane  <= '0;
            out_w     <= '0;
            out_idx   <= '0;
        end else begin
            out_valid <= emit;
            out_lane  <= rd_a[LS-1:0];
            out_w     <= mem_w[rd_addr];
            out_idx   <= rd_a;
        end
    end

    // Spill counter
    always_ff @(posedge clk) begin
        if (!rst_n)    coll_cnt <= '0;
        else if (coll) coll_cnt <= coll_cnt + 1'b1;
    end

    // R3
    paused_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !out_valid);

    // R5
    not_early_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_idx[IDX_W-1:LS] <= $past(hd_grp)));

    // R8
    free_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !(emit && rd_addr == wr_addr)) |-> !mem_v[wr_addr]);

    // R8
    coll_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (coll_cnt == $past(coll_cnt) || coll_cnt == $past(coll_cnt) + 1'b1));
endmodule

// File: tb/sim_evsched_top.sv
module sim_evsched_top;
    localparam int CLK_PERIOD = 10;
    localparam int LANES  = 4;
    localparam int NBUCK  = 8;
    localparam int SLOTS  = 2;
    localparam int IDX_W  = 16;
    localparam int P_W    = 8;
    localparam int COLL_W = 16;
    localparam int LS     = 2;

    logic clk = 1'b0;
    logic rst_n, run, ld_en;
    logic [P_W-1:0]    ld_p;
    logic [IDX_W-1:0]  ld_a;
    logic [7:0]        ld_w;
    logic              out_valid;
    logic [LS-1:0]     out_lane;
    logic [7:0]        out_w;
    logic [IDX_W-1:0]  out_idx;
    logic [COLL_W-1:0] coll_cnt;

    evsched_top #(.LANES(LANES), .NBUCK(NBUCK), .SLOTS(SLOTS), .IDX_W(IDX_W),
                  .P_W(P_W), .COLL_W(COLL_W)) u0 (
        .clk(clk), .rst_n(rst_n), .run(run), .ld_en(ld_en), .ld_p(ld_p),
        .ld_a(ld_a), .ld_w(ld_w), .out_valid(out_valid), .out_lane(out_lane),
        .out_w(out_w), .out_idx(out_idx), .coll_cnt(coll_cnt));

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0, errors = 0, nrun = 0, np = 0, nvalid = 0;
    int pp[4], ex[4], fg[4], fr[4];
    logic [7:0] ww[4];
    bit last_run = 0, done = 0;

    task automatic chk(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Compare an observed contribution with the progression model
    task automatic observe();
        int k, g, gi;
        if (!out_valid) return;
        nvalid++;
        if (!last_run) begin
            chk(0, "R3", "output after paused cycle", 1, 0);
            return;
        end
        k = -1;
        for (int i = 0; i < np; i++) if (ww[i] == out_w) k = i;
        if (k < 0) begin
            chk(0, "R2", "contribution with unknown weight", int'(out_w), 0);
            return;
        end
        g  = (nrun - 1) / SLOTS;
        gi = ex[k] / LANES;
        chk(int'(out_idx) == ex[k], "R7", "index sequence", int'(out_idx), ex[k]);
        chk(int'(out_lane) == ex[k] % LANES, "R6", "lane", int'(out_lane), ex[k] % LANES);
        chk(gi == g || (coll_cnt != 0 && gi == g - 1), "R5", "emission group", g, gi);
        if (fg[k] < 0) begin
            fg[k] = g;
            fr[k] = nrun - 1;
        end
        ex[k] += pp[k];
    endtask

    task automatic tick();
        @(posedge clk);
        last_run = run;
        if (run) nrun++;
        @(negedge clk);
        observe();
    endtask

    task automatic do_reset();
        run = 0; ld_en = 0; ld_p = '0; ld_a = '0; ld_w = '0;
        rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        nrun = 0; np = 0; last_run = 0; nvalid = 0;
    endtask

    task automatic load(int p, int a, int w);
        run = 0; ld_en = 1;
        ld_p = P_W'(p); ld_a = IDX_W'(a); ld_w = 8'(w);
        tick();
        ld_en = 0;
        pp[np] = p; ex[np] = a; ww[np] = 8'(w); fg[np] = -1; fr[np] = -1;
        np++;
    endtask

    task automatic run_for(int n);
        run = 1;
        repeat (n) tick();
        run = 0;
    endtask

    task automatic end_cov();
        int G;
        G = nrun / SLOTS;
        for (int k = 0; k < np; k++)
            chk(ex[k] / LANES >= G - 1, "R7", "pending group after run", ex[k] / LANES, G - 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        // R1: reset state and idle run
        do_reset();
        @(negedge clk);
        chk(out_valid == 0, "R1", "out_valid after reset", int'(out_valid), 0);
        chk(coll_cnt == 0, "R1", "coll_cnt after reset", int'(coll_cnt), 0);
        run_for(40);
        chk(nvalid == 0, "R9", "contributions from empty memory", nvalid, 0);

        // R4/R2: single event; load attempted while running is ignored
        do_reset();
        load(12, 5, 8'h21);
        run = 1; ld_en = 1; ld_p = 8'd9; ld_a = 16'd13; ld_w = 8'hEE;
        repeat (5) tick();
        ld_en = 0;
        run_for(95);
        chk(fr[0] == 2, "R4", "read cycle of first emission", fr[0], 2);
        chk(coll_cnt == 0, "R2", "coll_cnt after ignored load", int'(coll_cnt), 0);
        end_cov();

        // R5: event one lap ahead is held until its group
        do_reset();
        load(8, 41, 8'h31);
        run_for(60);
        chk(fg[0] == 10, "R5", "first emission group for lap-ahead event", fg[0], 10);
        end_cov();

        // R8: three events in one group force a spill
        do_reset();
        load(16, 4, 8'h41);
        load(16, 5, 8'h42);
        load(16, 6, 8'h43);
        chk(coll_cnt == 1, "R8", "coll_cnt after third load", int'(coll_cnt), 1);
        run_for(200);
        chk(fg[0] == 1, "R8", "group of first event", fg[0], 1);
        chk(fg[1] == 1, "R8", "group of second event", fg[1], 1);
        chk(fg[2] == 2, "R8", "group of spilled event", fg[2], 2);
        chk(fr[0] == 2, "R8", "lowest slot takes first load", fr[0], 2);
        end_cov();

        // R3: pause window
        do_reset();
        load(10, 2, 8'h51);
        run_for(20);
        nvalid = 0;
        repeat (10) tick();
        chk(nvalid == 0, "R3", "contributions while paused", nvalid, 0);
        run_for(60);
        end_cov();

        // Random progressions
        for (int r = 0; r < 6; r++) begin
            do_reset();
            for (int k = 0; k < 3; k++)
                load(8 + int'($urandom_range(12)), int'($urandom_range(31)), 8'h60 + r * 4 + k);
            run_for(300);
            end_cov();
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule